// File: doc/BRIEF.md
# Multi-Source Interrupt Level Controller

This block gathers thirty-two raw device request lines, one counter/timer request per processor and a word of software requests per processor. It reduces them to one 4-bit interrupt level per processor, for up to four processors. Each device line has its own mask bit. A master bit in the same mask word blocks every hardware request. Software sets and clears mask bits with write-one-to-set and write-one-to-clear accesses on a small register bus.

Device requests share the levels through a fixed many-to-one table. They are steered to the one processor named in a target register. Asynchronous error sources are merged into level 15 and reach every processor. The counter/timer input of each processor drives level 14 on that processor only. Each output is the highest level requested. It is registered, so it follows its inputs one clock later.

Register map (word addresses on `bus_addr`):

| Address | Read | Write |
|---|---|---|
| 0 | raw line state | ignored |
| 1 | mask word | ignored |
| 2 | 0 | mask set |
| 3 | 0 | mask clear |
| 4 | target index | target index |
| 8+2c | soft word of CPU c | soft set |
| 9+2c | soft word of CPU c | soft clear |

The block has no sequencing states. Its only state is the mask word, the target index, the soft words and the registered levels.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset, the mask word reads 0xFFFFFFFF, the target reads 0, every soft word reads 0 and every `pil_o` field is 0.
- R2: A write to address 2 sets each mask bit whose written bit is 1. A source whose mask bit is 1 produces no level.
- R3: A write to address 3 clears each mask bit whose written bit is 1. Bits written as 0 in a set or clear access leave the mask unchanged.
- R4: While mask bit 31 is 1, no line or timer input produces any level on any processor. Soft requests are still delivered.
- R5: The unmasked device lines map to levels as follows:
  - Bits 7..13 are expansion levels 1..7 and bits 0..6 are VME levels 1..7. Expansion/VME levels 1..7 map to levels 2, 3, 5, 7, 9, 11 and 13.
  - Bit 18 maps to level 4, bit 16 to 6, bit 20 to 8, bit 21 to 9, bit 19 to 10 and bit 22 to 11.
  - Bits 15 and 14 map to level 12, and bit 17 maps to level 13.
- R6: Any unmasked line among bits 30..27 requests level 15 on every processor, whatever the target.
- R7: `tmr_i[c]` requests level 14 on processor c alone, and only while mask bit 7 is 0.
- R8: In soft word c, bit 16+n (n = 1..15) requests level n on processor c. Writes to 8+2c set the bits written as 1 and writes to 9+2c clear them. Bits 16..0 always read 0.
- R9: Mapped device levels (R5) reach only the processor whose index is held in the target register (address 4).
- R10: Address 0 reads the current raw `dev_lines_i`, unaffected by any mask.
- R11: `pil_o` field c, bits 4c+3..4c, holds the highest level requested on processor c, or 0 if none. It is registered one clock after its inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_lines_i | input | 32 | Raw device and error request lines |
| tmr_i | input | NCPU | Per-processor counter/timer request |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | AW | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| pil_o | output | 4*NCPU | Registered interrupt level per processor |

## Verification
The hardest situation to reach is one where several request kinds overlap on one processor:
- a soft request above a device request,
- an error broadcast,
- the master mask gating hardware but not software.

The stimulus builds this up in steps. It first unmasks only the sources it needs, then layers a soft request, an error line and the master mask one at a time. It checks every processor's field after each step, so that steering and broadcast are told apart.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
    localparam int WORD_W     = 32;
    localparam int LVL_W      = 4;
    localparam int NLVL       = 16;
    localparam int MASTER_BIT = 31;
    localparam int TMR_EN_BIT = 7;
    localparam int ERR_LO     = 27;
    localparam int ERR_HI     = 30;
    localparam int SOFT_LO    = 17;

    localparam int A_RAW      = 0;
    localparam int A_MASK     = 1;
    localparam int A_MSET     = 2;
    localparam int A_MCLR     = 3;
    localparam int A_TGT      = 4;
    localparam int A_SOFT     = 8;

    // expansion/VME pair k (1..7) -> processor level
    function automatic int pair_level(input int k);
        return (k == 1) ? 2 : 2 * k - 1;
    endfunction

    // unmasked device lines -> request vector indexed by level
    function automatic logic [NLVL-1:0] dev_levels(input logic [WORD_W-1:0] act);
        logic [NLVL-1:0] l;
        l = '0;
        for (int k = 1; k <= 7; k++) begin
            l[pair_level(k)] = l[pair_level(k)] | act[6 + k] | act[k - 1];
        end
        l[4]  = l[4]  | act[18];
        l[6]  = l[6]  | act[16];
        l[8]  = l[8]  | act[20];
        l[9]  = l[9]  | act[21];
        l[10] = l[10] | act[19];
        l[11] = l[11] | act[22];
        l[12] = l[12] | act[15] | act[14];
        l[13] = l[13] | act[17];
        return l;
    endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_lvl_pkg::*;
#(
    parameter int NCPU = 4,
    parameter int AW   = 4,
    parameter int TW   = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic [AW-1:0]          bus_addr,
    input  logic [WORD_W-1:0]      bus_wdata,
    output logic [WORD_W-1:0]      mask_q,
    output logic [TW-1:0]          target_q,
    output logic [NCPU*WORD_W-1:0] soft_q
);
    localparam logic [WORD_W-1:0] SOFT_KEEP = {{(WORD_W-SOFT_LO){1'b1}}, {SOFT_LO{1'b0}}};

    wire wr_set = bus_wr && (bus_addr == AW'(A_MSET));
    wire wr_clr = bus_wr && (bus_addr == AW'(A_MCLR));
    wire wr_tgt = bus_wr && (bus_addr == AW'(A_TGT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q   <= '1;
            target_q <= '0;
        end else begin
            if (wr_set)
                mask_q <= mask_q | bus_wdata;
            else if (wr_clr)
                mask_q <= mask_q & ~bus_wdata;
            if (wr_tgt)
                target_q <= bus_wdata[TW-1:0];
        end
    end

    for (genvar c = 0; c < NCPU; c++) begin : g_soft
        wire s_set = bus_wr && (bus_addr == AW'(A_SOFT + 2 * c));
        wire s_clr = bus_wr && (bus_addr == AW'(A_SOFT + 2 * c + 1));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                soft_q[c*WORD_W +: WORD_W] <= '0;
            else if (s_set)
                soft_q[c*WORD_W +: WORD_W] <= soft_q[c*WORD_W +: WORD_W] | (bus_wdata & SOFT_KEEP);
            else if (s_clr)
                soft_q[c*WORD_W +: WORD_W] <= soft_q[c*WORD_W +: WORD_W] & ~(bus_wdata & SOFT_KEEP);
        end
        // R8: the low soft bits never hold a request
        a_r8_soft_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
            s_set |=> soft_q[c*WORD_W +: SOFT_LO] == '0);
    end

    // R2: every written one is masked afterwards
    a_r2_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));
    // R3: every written one is unmasked, zeros keep their value
    a_r3_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> (((mask_q & $past(bus_wdata)) == '0) &&
                   ((mask_q & ~$past(bus_wdata)) == ($past(mask_q) & ~$past(bus_wdata)))));
endmodule

// File: rtl/irq_src_map.sv
module irq_src_map
    import irq_lvl_pkg::*;
#(
    parameter int NCPU = 4,
    parameter int TW   = 2
) (
    input  logic [WORD_W-1:0]    lines,
    input  logic [WORD_W-1:0]    mask,
    input  logic [TW-1:0]        target,
    input  logic [NCPU-1:0]      tmr,
    output logic [NCPU*NLVL-1:0] hw_req
);
    logic [WORD_W-1:0] act;
    logic [NLVL-1:0]   dev;
    logic              err;
    logic              tmr_open;

    always_comb begin
        act      = mask[MASTER_BIT] ? '0 : (lines & ~mask);
        dev      = dev_levels(act);
        err      = |act[ERR_HI:ERR_LO];
        tmr_open = !mask[MASTER_BIT] && !mask[TMR_EN_BIT];
    end

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        always_comb begin
            hw_req[c*NLVL +: NLVL] = (target == TW'(c)) ? dev : '0;
            hw_req[c*NLVL + 15]    = err;
            hw_req[c*NLVL + 14]    = tmr[c] && tmr_open;
        end
    end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import irq_lvl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NLVL-1:0]  req,
    output logic [LVL_W-1:0] pil_q
);
    logic [LVL_W-1:0] pick;

    always_comb begin
        pick = '0;
        for (int i = 1; i < NLVL; i++) begin
            if (req[i]) pick = LVL_W'(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pil_q <= '0;
        else        pil_q <= pick;
    end

    // R11: idle requests give level 0
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req[NLVL-1:1] == '0) |=> (pil_q == '0));
    // R11: the top level always wins
    a_r11_top_wins: assert property (@(posedge clk) disable iff (!rst_n)
        req[NLVL-1] |=> (pil_q == LVL_W'(NLVL-1)));
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
    import irq_lvl_pkg::*;
#(
    parameter int NCPU = 4,
    parameter int AW   = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [WORD_W-1:0]     dev_lines_i,
    input  logic [NCPU-1:0]       tmr_i,
    input  logic                  bus_wr,
    input  logic [AW-1:0]         bus_addr,
    input  logic [WORD_W-1:0]     bus_wdata,
    output logic [WORD_W-1:0]     bus_rdata,
    output logic [NCPU*LVL_W-1:0] pil_o
);
    localparam int TW = (NCPU > 1) ? $clog2(NCPU) : 1;

    logic [WORD_W-1:0]      mask_q;
    logic [TW-1:0]          target_q;
    logic [NCPU*WORD_W-1:0] soft_q;
    logic [NCPU*NLVL-1:0]   hw_req;

    irq_cfg_regs #(.NCPU(NCPU), .AW(AW), .TW(TW)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .mask_q(mask_q), .target_q(target_q), .soft_q(soft_q)
    );

    irq_src_map #(.NCPU(NCPU), .TW(TW)) u_map (
        .lines(dev_lines_i), .mask(mask_q), .target(target_q), .tmr(tmr_i), .hw_req(hw_req)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_enc
        logic [NLVL-1:0] req;
        assign req = hw_req[c*NLVL +: NLVL] |
                     {soft_q[c*WORD_W + SOFT_LO +: NLVL-1], 1'b0};
        irq_prio_enc u_enc (
            .clk(clk), .rst_n(rst_n), .req(req), .pil_q(pil_o[c*LVL_W +: LVL_W])
        );

        // R4: master mask with no soft request leaves the processor idle
        a_r4_master_blocks: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_q[MASTER_BIT] && soft_q[c*WORD_W +: WORD_W] == '0)
            |=> (pil_o[c*LVL_W +: LVL_W] == '0));
        // R9: a processor that is not the target sees no device level
        a_r9_steer_only: assert property (@(posedge clk) disable iff (!rst_n)
            (target_q != TW'(c) && !tmr_i[c] && soft_q[c*WORD_W +: WORD_W] == '0 &&
             (dev_lines_i[ERR_HI:ERR_LO] & ~mask_q[ERR_HI:ERR_LO]) == '0)
            |=> (pil_o[c*LVL_W +: LVL_W] == '0));
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            AW'(A_RAW):  bus_rdata = dev_lines_i;
            AW'(A_MASK): bus_rdata = mask_q;
            AW'(A_TGT):  bus_rdata = WORD_W'(target_q);
            default: begin
                for (int c = 0; c < NCPU; c++) begin
                    if (bus_addr == AW'(A_SOFT + 2 * c) || bus_addr == AW'(A_SOFT + 2 * c + 1))
                        bus_rdata = soft_q[c*WORD_W +: WORD_W];
                end
            end
        endcase
    end
endmodule

// File: tb/test_irq_level_ctrl.sv
`timescale 1ns/1ps
module test_irq_level_ctrl;
    localparam int NCPU = 4;
    localparam int AW   = 4;
    localparam int NV   = 24;

    logic              clk = 0;
    logic              rst_n = 0;
    logic [31:0]       lines = '0;
    logic [NCPU-1:0]   tmr = '0;
    logic              wr = 0;
    logic [AW-1:0]     addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic [NCPU*4-1:0] pil;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_level_ctrl #(.NCPU(NCPU), .AW(AW)) i_irq_level_ctrl (
        .clk(clk), .rst_n(rst_n), .dev_lines_i(lines), .tmr_i(tmr), .bus_wr(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .pil_o(pil)
    );

    // {lines, level on target CPU 0, level on other CPUs}  (R5, R6)
    localparam logic [39:0] VEC [NV] = '{
        {32'h0004_0000, 4'd4,  4'd0}, {32'h0001_0000, 4'd6,  4'd0},
        {32'h0010_0000, 4'd8,  4'd0}, {32'h0008_0000, 4'd10, 4'd0},
        {32'h0040_0000, 4'd11, 4'd0}, {32'h0000_8000, 4'd12, 4'd0},
        {32'h0000_4000, 4'd12, 4'd0}, {32'h0002_0000, 4'd13, 4'd0},
        {32'h0020_0000, 4'd9,  4'd0}, {32'h0000_0080, 4'd2,  4'd0},
        {32'h0000_0001, 4'd2,  4'd0}, {32'h0000_0100, 4'd3,  4'd0},
        {32'h0000_0002, 4'd3,  4'd0}, {32'h0000_0200, 4'd5,  4'd0},
        {32'h0000_0400, 4'd7,  4'd0}, {32'h0000_0800, 4'd9,  4'd0},
        {32'h0000_1000, 4'd11, 4'd0}, {32'h0000_2000, 4'd13, 4'd0},
        {32'h0000_0040, 4'd13, 4'd0}, {32'h0005_0000, 4'd6,  4'd0},
        {32'h1000_0000, 4'd15, 4'd15}, {32'h4004_0000, 4'd15, 4'd15},
        {32'h0800_0001, 4'd15, 4'd15}, {32'h0000_0000, 4'd0,  4'd0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_reg(input int a, input logic [31:0] d);
        @(negedge clk);
        addr = AW'(a); wdata = d; wr = 1;
        @(negedge clk);
        wr = 0;
    endtask

    task automatic rd_reg(input int a, output logic [31:0] d);
        @(negedge clk);
        addr = AW'(a);
        #1 d = rdata;
    endtask

    function automatic int lvl(input int c);
        return int'(pil[c*4 +: 4]);
    endfunction

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        for (int c = 0; c < NCPU; c++) chk("R1 pil", lvl(c), 0);
        rd_reg(1, d); chk("R1 mask", d, 32'hFFFF_FFFF);
        rd_reg(4, d); chk("R1 target", d, 0);
        for (int c = 0; c < NCPU; c++) begin rd_reg(8 + 2 * c, d); chk("R1 soft", d, 0); end
        // R10 raw read
        lines = 32'h1234_5678; rd_reg(0, d); chk("R10 raw", d, 32'h1234_5678);
        // R4 master mask
        lines = 32'h0004_0000; settle(); chk("R2 masked at reset", lvl(0), 0);
        wr_reg(3, 32'h7FFF_FFFF); settle();
        chk("R4 master blocks", lvl(0), 0);
        rd_reg(1, d); chk("R3 mask after clear", d, 32'h8000_0000);
        wr_reg(8, 32'h0008_0000); settle(); chk("R4 soft under master", lvl(0), 3);
        wr_reg(9, 32'h0008_0000);
        wr_reg(3, 32'h8000_0000); settle(); chk("R4 master open", lvl(0), 4);
        // R5/R6 table
        for (int i = 0; i < NV; i++) begin
            lines = VEC[i][39:8];
            settle();
            chk("R5 target level", lvl(0), int'(VEC[i][7:4]));
            for (int c = 1; c < NCPU; c++) chk("R6 other cpu", lvl(c), int'(VEC[i][3:0]));
        end
        // R2 / R3 write-one semantics
        wr_reg(2, 32'h0004_0000); lines = 32'h0004_0000; settle();
        chk("R2 set masks", lvl(0), 0);
        rd_reg(1, d); chk("R2 mask read", d, 32'h0004_0000);
        wr_reg(3, 32'h0); rd_reg(1, d); chk("R3 zero write", d, 32'h0004_0000);
        wr_reg(3, 32'h0004_0000); settle(); chk("R3 clear unmasks", lvl(0), 4);
        // R9 steering
        wr_reg(4, 32'd2); settle();
        chk("R9 target cpu", lvl(2), 4);
        chk("R9 old target idle", lvl(0), 0);
        rd_reg(4, d); chk("R9 target read", d, 2);
        wr_reg(4, 32'd0); lines = '0;
        // R7 timer
        tmr = 4'b0010; settle();
        chk("R7 timer cpu", lvl(1), 14);
        chk("R7 timer local", lvl(0), 0);
        wr_reg(2, 32'h0000_0080); settle(); chk("R7 timer masked", lvl(1), 0);
        wr_reg(3, 32'h0000_0080); tmr = '0;
        // R8 soft
        wr_reg(14, 32'h0001_0000); settle();
        chk("R8 soft n0 ignored", lvl(3), 0);
        rd_reg(14, d); chk("R8 soft low read", d, 0);
        wr_reg(14, 32'h8010_0000); settle(); chk("R8 soft 15", lvl(3), 15);
        rd_reg(15, d); chk("R8 soft read", d, 32'h8010_0000);
        wr_reg(15, 32'h8000_0000); settle(); chk("R8 soft clear", lvl(3), 4);
        wr_reg(15, 32'hFFFF_FFFF); settle(); chk("R8 soft all clear", lvl(3), 0);
        // R11 priority across kinds
        lines = 32'h0004_0000; wr_reg(8, 32'h0020_0000); settle();
        chk("R11 soft above device", lvl(0), 5);
        lines = 32'h4004_0000; settle();
        for (int c = 0; c < NCPU; c++) chk("R11 error wins", lvl(c), 15);
        wr_reg(2, 32'h8000_0000); settle();
        chk("R4 soft kept", lvl(0), 5);
        chk("R4 error blocked", lvl(1), 0);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule